// File: doc/BRIEF.md
# Periodic Limit Alarm Controller

This block supervises a measurement engine that converts on a fixed schedule. A timer opens one conversion at the start of every period. The period length comes from a 4-bit rate code, and the engine reports itself busy for a fixed number of cycles at the head of each period. On the last busy cycle the block samples the measurement input and compares it against an upper and a lower limit. A violation sets a sticky status flag. The block pulls an active-low alert line while any flag is set, unless the alert is masked.

The host side arrives as single-cycle pulses: a register write (address plus data), a status-register read, and an access to the bus alert-response address. Limit writes are staged in a pending copy and only reach the comparator at the end of the next conversion. A status read releases the flags only once the latest conversion is clean. An alert-response access sets the mask bit as a side effect. The mask silences the alert line at once but leaves the flags untouched.

Top module: `limit_alert_ctrl`

## Requirements
- R1: The period in clock cycles is `(16*CLK_HZ) >> min(code, MAX_CODE)`, raised to `CONV_CYC+1` if smaller. The code is written as `wr_data_i[3:0]` at address `ADDR_RATE` (0x0A) and is used from the cycle after the write.
- R2: `busy_o` is 1 for the first `CONV_CYC` cycles of every period and 0 for the rest. The first period begins in the first cycle after reset.
- R3: On the last busy cycle of a period the block samples `meas_i`, an unsigned value. `meas_i > active upper` sets `status_o[1]`, and `meas_i < active lower` sets `status_o[0]`. Flags stay set when later conversions are clean.
- R4: Writes at `ADDR_HI` (0x0B) and `ADDR_LO` (0x0C) load a pending copy. The pending copy becomes active at the end of the next conversion and is first used by the conversion after that.
- R5: A status-read pulse clears both flags only when the most recent conversion violated neither limit. Otherwise it has no effect.
- R6: A status read in the same cycle as the end of a conversion sets the flags to that conversion's result.
- R7: `alert_n_o` is 0 exactly when some flag is set and the mask is clear.
- R8: An alert-response pulse sets the mask, and it wins over a config write in the same cycle. The mask is written as `wr_data_i[7]` at `ADDR_CFG_WR` (0x09) and otherwise holds its value.
- R9: Setting the mask drives the alert high in the cycle `mask_o` rises and leaves the flags unchanged. Clearing the mask while a flag is set pulls the alert low again.
- R10: Reset clears the mask and the flags, loads `HI_DEF`/`LO_DEF` into both limit copies, loads `RATE_DEF`, and sets `busy_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_i | input | DW | Measurement value, sampled at the end of each conversion |
| wr_stb_i | input | 1 | Register write pulse |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | DW | Register write data |
| stat_rd_i | input | 1 | Status-register read pulse |
| ara_i | input | 1 | Alert-response-address access pulse |
| busy_o | output | 1 | Conversion in progress |
| alert_n_o | output | 1 | Active-low alert |
| mask_o | output | 1 | Current mask bit |
| status_o | output | 2 | Sticky flags: [1] above upper, [0] below lower |

## Verification
A wrong timer count shows on `busy_o` within one period. A late or early limit swap changes the flag pattern at the first conversion boundary after a limit write. A wrong flag or condition register shows on `status_o` and `alert_n_o` no later than the next status read or conversion end. A behavioural model follows every register from reset and is compared on all four outputs every cycle, so a wrong state is reported in the cycle it first reaches a port.

// File: rtl/lac_pkg.sv
package lac_pkg;
    typedef logic [1:0] lac_flags_t;
    localparam int FLAG_HI  = 1;
    localparam int FLAG_LO  = 0;
    localparam int MASK_BIT = 7;
    localparam int CODE_W   = 4;
endpackage

// File: rtl/lac_conv_timer.sv
module lac_conv_timer #(
    parameter int unsigned CLK_HZ   = 1000000,
    parameter int unsigned CONV_CYC = 1000,
    parameter int unsigned MAX_CODE = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [lac_pkg::CODE_W-1:0] rate_i,
    output logic                      busy_o,
    output logic                      done_o
);
    localparam int unsigned SLOW_CYC = 16 * CLK_HZ;
    localparam int          CNT_W    = $clog2(SLOW_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] tick;
    } tmr_t;

    tmr_t                     s_d, s_q;
    logic [lac_pkg::CODE_W-1:0] eff_code;
    logic [CNT_W-1:0]         shifted;
    logic [CNT_W-1:0]         period;

    always_comb begin
        eff_code = (rate_i > lac_pkg::CODE_W'(MAX_CODE)) ? lac_pkg::CODE_W'(MAX_CODE) : rate_i;
        shifted  = CNT_W'(SLOW_CYC) >> eff_code;
        period   = (shifted < CNT_W'(CONV_CYC + 1)) ? CNT_W'(CONV_CYC + 1) : shifted;
        s_d      = s_q;
        s_d.tick = (s_q.tick >= period - 1'b1) ? '0 : s_q.tick + 1'b1;
        busy_o   = s_q.tick < CNT_W'(CONV_CYC);
        done_o   = s_q.tick == CNT_W'(CONV_CYC - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/lac_limit_regs.sv
module lac_limit_regs #(
    parameter int          DW        = 12,
    parameter logic [7:0]  ADDR_RATE = 8'h0A,
    parameter logic [7:0]  ADDR_HI   = 8'h0B,
    parameter logic [7:0]  ADDR_LO   = 8'h0C,
    parameter int unsigned HI_DEF    = 2000,
    parameter int unsigned LO_DEF    = 100,
    parameter int unsigned RATE_DEF  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb_i,
    input  logic [7:0]                  wr_addr_i,
    input  logic [DW-1:0]               wr_data_i,
    input  logic                        done_i,
    output logic [DW-1:0]               act_hi_o,
    output logic [DW-1:0]               act_lo_o,
    output logic [lac_pkg::CODE_W-1:0]  rate_o
);
    typedef struct packed {
        logic [DW-1:0]              pend_hi;
        logic [DW-1:0]              pend_lo;
        logic [DW-1:0]              act_hi;
        logic [DW-1:0]              act_lo;
        logic [lac_pkg::CODE_W-1:0] rate;
    } lim_t;

    lim_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // staged values move to the comparator only at a conversion end
        if (done_i) begin
            r_d.act_hi = r_q.pend_hi;
            r_d.act_lo = r_q.pend_lo;
        end
        if (wr_stb_i) begin
            if (wr_addr_i == ADDR_HI)   r_d.pend_hi = wr_data_i;
            if (wr_addr_i == ADDR_LO)   r_d.pend_lo = wr_data_i;
            if (wr_addr_i == ADDR_RATE) r_d.rate    = wr_data_i[lac_pkg::CODE_W-1:0];
        end
        act_hi_o = r_q.act_hi;
        act_lo_o = r_q.act_lo;
        rate_o   = r_q.rate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pend_hi <= DW'(HI_DEF);
            r_q.pend_lo <= DW'(LO_DEF);
            r_q.act_hi  <= DW'(HI_DEF);
            r_q.act_lo  <= DW'(LO_DEF);
            r_q.rate    <= lac_pkg::CODE_W'(RATE_DEF);
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/lac_alarm.sv
module lac_alarm #(
    parameter int DW = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       meas_i,
    input  logic [DW-1:0]       act_hi_i,
    input  logic [DW-1:0]       act_lo_i,
    input  logic                done_i,
    input  logic                stat_rd_i,
    input  logic                ara_i,
    input  logic                cfg_wr_i,
    input  logic                cfg_mask_i,
    output lac_pkg::lac_flags_t status_o,
    output logic                mask_o,
    output logic                alert_n_o
);
    import lac_pkg::*;

    typedef struct packed {
        lac_flags_t st;
        lac_flags_t cond;
        logic       mask;
    } alm_t;

    alm_t       a_d, a_q;
    lac_flags_t viol;

    always_comb begin
        viol          = '0;
        viol[FLAG_HI] = meas_i > act_hi_i;
        viol[FLAG_LO] = meas_i < act_lo_i;
        a_d = a_q;
        if (done_i) begin
            // a fresh result outranks a read landing in the same cycle
            a_d.st   = stat_rd_i ? viol : (a_q.st | viol);
            a_d.cond = viol;
        end else if (stat_rd_i && (a_q.cond == '0)) begin
            a_d.st = '0;
        end
        if (ara_i)         a_d.mask = 1'b1;
        else if (cfg_wr_i) a_d.mask = cfg_mask_i;
        status_o  = a_q.st;
        mask_o    = a_q.mask;
        alert_n_o = !((a_q.st != '0) && !a_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end
endmodule

// File: rtl/limit_alert_ctrl.sv
module limit_alert_ctrl #(
    parameter int          DW          = 12,
    parameter int unsigned CLK_HZ      = 1000000,
    parameter int unsigned CONV_CYC    = 1000,
    parameter int unsigned MAX_CODE    = 8,
    parameter int unsigned HI_DEF      = 2000,
    parameter int unsigned LO_DEF      = 100,
    parameter int unsigned RATE_DEF    = 8,
    parameter logic [7:0]  ADDR_CFG_WR = 8'h09,
    parameter logic [7:0]  ADDR_RATE   = 8'h0A,
    parameter logic [7:0]  ADDR_HI     = 8'h0B,
    parameter logic [7:0]  ADDR_LO     = 8'h0C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] meas_i,
    input  logic          wr_stb_i,
    input  logic [7:0]    wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          stat_rd_i,
    input  logic          ara_i,
    output logic          busy_o,
    output logic          alert_n_o,
    output logic          mask_o,
    output logic [1:0]    status_o
);
    logic                       done;
    logic [DW-1:0]              act_hi, act_lo;
    logic [lac_pkg::CODE_W-1:0] rate;
    logic                       cfg_wr;

    assign cfg_wr = wr_stb_i && (wr_addr_i == ADDR_CFG_WR);

    lac_conv_timer #(
        .CLK_HZ(CLK_HZ), .CONV_CYC(CONV_CYC), .MAX_CODE(MAX_CODE)
    ) tmr_i (
        .clk(clk), .rst_n(rst_n), .rate_i(rate), .busy_o(busy_o), .done_o(done)
    );

    lac_limit_regs #(
        .DW(DW), .ADDR_RATE(ADDR_RATE), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO),
        .HI_DEF(HI_DEF), .LO_DEF(LO_DEF), .RATE_DEF(RATE_DEF)
    ) lim_i (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .done_i(done), .act_hi_o(act_hi), .act_lo_o(act_lo),
        .rate_o(rate)
    );

    lac_alarm #(.DW(DW)) alm_i (
        .clk(clk), .rst_n(rst_n), .meas_i(meas_i), .act_hi_i(act_hi), .act_lo_i(act_lo),
        .done_i(done), .stat_rd_i(stat_rd_i), .ara_i(ara_i), .cfg_wr_i(cfg_wr),
        .cfg_mask_i(wr_data_i[lac_pkg::MASK_BIT]), .status_o(status_o),
        .mask_o(mask_o), .alert_n_o(alert_n_o)
    );
endmodule

// File: rtl/lac_checker.sv
module lac_checker #(
    parameter logic [7:0] CFG_ADDR = 8'h09
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb_i,
    input logic [7:0] wr_addr_i,
    input logic       stat_rd_i,
    input logic       ara_i,
    input logic       busy_o,
    input logic       alert_n_o,
    input logic       mask_o,
    input logic [1:0] status_o
);
    // R8
    ara_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ara_i |=> mask_o);

    // R8
    mask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o && !(wr_stb_i && wr_addr_i == CFG_ADDR)) |=> mask_o);

    // R9
    mask_quiets_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_o) |-> alert_n_o);

    // R7
    unmasked_flag_alerts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_o && status_o != 2'b00) |-> !alert_n_o);

    // R3
    flag_rise_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~$past(status_o)) != 2'b00) |-> $past(busy_o));

    // R9
    ara_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_i && !busy_o && !stat_rd_i) |=> status_o == $past(status_o));
endmodule

bind limit_alert_ctrl lac_checker #(.CFG_ADDR(ADDR_CFG_WR)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb_i), .wr_addr_i(wr_addr_i),
    .stat_rd_i(stat_rd_i), .ara_i(ara_i), .busy_o(busy_o), .alert_n_o(alert_n_o),
    .mask_o(mask_o), .status_o(status_o)
);

// File: tb/limit_alert_ctrl_tb_top.sv
`timescale 1ns/1ps
module limit_alert_ctrl_tb_top;
    localparam int DW       = 12;
    localparam int CLK_HZ   = 64;
    localparam int CONV     = 3;
    localparam int MAXC     = 8;
    localparam int HI_DEF   = 2000;
    localparam int LO_DEF   = 100;
    localparam int RATE_DEF = 8;
    localparam logic [7:0] A_CFG = 8'h09, A_RATE = 8'h0A, A_HI = 8'h0B, A_LO = 8'h0C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] meas = 12'd1000;
    logic          wr_stb = 1'b0;
    logic [7:0]    wr_addr = 8'h00;
    logic [DW-1:0] wr_data = '0;
    logic          stat_rd = 1'b0;
    logic          ara = 1'b0;
    logic          busy, alert_n, mask;
    logic [1:0]    status;

    always #10 clk = ~clk;

    limit_alert_ctrl #(
        .DW(DW), .CLK_HZ(CLK_HZ), .CONV_CYC(CONV), .MAX_CODE(MAXC),
        .HI_DEF(HI_DEF), .LO_DEF(LO_DEF), .RATE_DEF(RATE_DEF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .meas_i(meas), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .stat_rd_i(stat_rd), .ara_i(ara), .busy_o(busy),
        .alert_n_o(alert_n), .mask_o(mask), .status_o(status)
    );

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string tag = "R10";
    bit    cmp_on = 0;

    // behavioural reference state
    int m_tick, m_rate, m_phi, m_plo, m_ahi, m_alo, m_per, m_eff;
    bit m_sh, m_sl, m_ch, m_cl, m_mask, m_done, m_vh, m_vl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick = 0; m_rate = RATE_DEF; m_mask = 0;
            m_phi = HI_DEF; m_ahi = HI_DEF; m_plo = LO_DEF; m_alo = LO_DEF;
            m_sh = 0; m_sl = 0; m_ch = 0; m_cl = 0;
        end else begin
            m_eff = (m_rate > MAXC) ? MAXC : m_rate;
            m_per = (16 * CLK_HZ) >> m_eff;
            if (m_per < CONV + 1) m_per = CONV + 1;
            m_done = (m_tick == CONV - 1);
            if (m_done) begin
                m_vh = int'(meas) > m_ahi;
                m_vl = int'(meas) < m_alo;
                if (stat_rd) begin m_sh = m_vh; m_sl = m_vl; end
                else begin m_sh = m_sh | m_vh; m_sl = m_sl | m_vl; end
                m_ch = m_vh; m_cl = m_vl;
                m_ahi = m_phi; m_alo = m_plo;
            end else if (stat_rd && !m_ch && !m_cl) begin
                m_sh = 0; m_sl = 0;
            end
            if (wr_stb) begin
                if (wr_addr == A_HI)   m_phi = int'(wr_data);
                if (wr_addr == A_LO)   m_plo = int'(wr_data);
                if (wr_addr == A_RATE) m_rate = int'(wr_data[3:0]);
                if (wr_addr == A_CFG && !ara) m_mask = wr_data[7];
            end
            if (ara) m_mask = 1;
            m_tick = (m_tick >= m_per - 1) ? 0 : m_tick + 1;
        end
        cmp_on = 1;
    end

    task automatic check1(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            check1("busy_o", int'(busy), (m_tick < CONV) ? 1 : 0);
            check1("status_o", int'(status), (m_sh ? 2 : 0) + (m_sl ? 1 : 0));
            check1("mask_o", int'(mask), int'(m_mask));
            check1("alert_n_o", int'(alert_n), ((m_sh || m_sl) && !m_mask) ? 0 : 1);
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, int d);
        wr_stb = 1; wr_addr = a; wr_data = DW'(d);
        @(negedge clk);
        wr_stb = 0;
    endtask

    task automatic rd();
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
    endtask

    task automatic ara_pulse();
        ara = 1;
        @(negedge clk);
        ara = 0;
    endtask

    task automatic rd_at_done();
        while (m_tick != CONV - 1) @(negedge clk);
        rd();
    endtask

    initial begin
        // R10: reset values seen on every output
        tag = "R10";
        idle(3);
        rst_n = 1;
        tag = "R2";
        idle(10);

        // R1: rate codes, including clamp above MAX_CODE
        tag = "R1";
        wr(A_RATE, 6);  idle(40);
        wr(A_RATE, 7);  idle(20);
        wr(A_RATE, 12); idle(12);
        wr(A_RATE, 0);  idle(1100);
        wr(A_RATE, 8);  idle(8);

        // R3 / R7: upper violation is sticky, alert low
        tag = "R3";
        meas = 12'd2500; idle(10);
        meas = 12'd1000; idle(10);
        tag = "R7";
        idle(4);

        // R5: read while still violating, then after a clean result
        tag = "R5";
        meas = 12'd2500; idle(8);
        rd(); idle(3);
        meas = 12'd1000; idle(8);
        rd(); idle(6);

        // R6: read coinciding with conversion end
        tag = "R6";
        meas = 12'd2500; idle(8);
        meas = 12'd1000; rd_at_done(); idle(6);
        meas = 12'd2500; rd_at_done(); idle(2);
        meas = 12'd1000; idle(8); rd(); idle(4);

        // R4: staged limits
        tag = "R4";
        idle(1); wr(A_HI, 500); idle(12);
        wr(A_HI, 2000); idle(10); rd(); idle(4);
        tag = "R3";
        meas = 12'd50; idle(8);
        meas = 12'd1000; idle(8); rd(); idle(4);
        tag = "R4";
        wr(A_LO, 1200); idle(2); wr(A_LO, 100); idle(12);
        rd(); idle(6);

        // R8 / R9: mask behaviour
        tag = "R9";
        meas = 12'd2500; idle(8);
        meas = 12'd1000;
        ara_pulse(); idle(6);
        wr(A_CFG, 0); idle(4);
        tag = "R8";
        ara = 1; wr(A_CFG, 0); ara = 0; idle(4);
        wr(A_CFG, 0); idle(2);
        wr(A_CFG, 8'h80); idle(4);
        wr(A_CFG, 0); idle(4);
        rd(); idle(6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule